// File: doc/BRIEF.md
# Host Byte Port with Command/Data Steering

This block is the slave side of an 8-bit host interface. An external host drives a chip-select, read and write strobes, a command/data select line and a per-byte error flag. Every strobe is sampled into the core clock domain. A write finishes on the rising edge of the write strobe while chip-select is low. When the select line is high, the byte is loaded into a command register. When it is low, the byte and its error flag go together into a small data FIFO, so the host can stream data in bursts.

A host read with the select line high returns the reply register. A read with the line low returns zero. The data bus is split into an input, an output and an output-enable, so the pad ring can form the bidirectional pin. A ready output tells the host whether more data may be sent. It falls before the FIFO is full, which leaves room for bytes the host already has in flight. On the core side, logic pops FIFO entries, acknowledges commands and loads replies.

Top module: `hbyte_port`

## Requirements
- R1: After reset, host_ready is 1, fifo_valid, fifo_ovf, cmd_pending, reply_valid and host_d_oe are 0, and cmd_word is 0x00.
- R2: A completed write with host_cd=1 (write strobe rises while host_cs_n is low) loads the byte into cmd_word and sets cmd_pending. The FIFO is not changed.
- R3: A one-cycle pulse on cmd_take clears cmd_pending and leaves cmd_word unchanged.
- R4: A completed write with host_cd=0 stores the byte and the host_err value sampled with it into the FIFO. Entries come out on fifo_data and fifo_err in the order they were written. A pulse on fifo_pop while fifo_valid is 1 moves to the next entry.
- R5: host_ready is 1 while more than 4 of the 16 FIFO slots are free. It is 0 when 12 or more entries are held.
- R6: A data write to a full FIFO is dropped and sets fifo_ovf. fifo_ovf stays set until reset, and the stored entries are not changed.
- R7: host_d_oe is 1 only while host_cs_n and host_rd_n are both low. During such a read, host_d_out shows the reply register when host_cd=1 and 0x00 when host_cd=0.
- R8: A pulse on reply_load copies reply_in into the reply register and sets reply_valid. A completed host read with host_cd=1 (read strobe rises while host_cs_n is low) clears reply_valid.
- R9: Strobes given while host_cs_n is high have no effect: cmd_word, cmd_pending and reply_valid keep their values.
- R10: fifo_pop while the FIFO is empty has no effect, and fifo_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Host chip-select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low; the write completes on its rising edge |
| host_cd | input | 1 | 1 selects the command/reply registers, 0 selects the data FIFO |
| host_err | input | 1 | Error flag for the byte being written |
| host_d_in | input | 8 | Host data bus, inbound half |
| host_d_out | output | 8 | Host data bus, outbound half |
| host_d_oe | output | 1 | Output enable for the host data bus |
| host_ready | output | 1 | 1 while the FIFO can take more data |
| fifo_pop | input | 1 | Core request to remove the head entry |
| fifo_data | output | 8 | Data byte of the head entry |
| fifo_err | output | 1 | Error tag of the head entry |
| fifo_valid | output | 1 | FIFO holds at least one entry |
| fifo_ovf | output | 1 | Sticky flag: a data write was dropped |
| cmd_word | output | 8 | Last command byte from the host |
| cmd_pending | output | 1 | A command is waiting for the core |
| cmd_take | input | 1 | Core acknowledge that clears cmd_pending |
| reply_load | input | 1 | Core strobe that loads the reply register |
| reply_in | input | 8 | Reply byte from the core |
| reply_valid | output | 1 | Reply is loaded and not yet read by the host |

## Verification
Data bytes are written with a mix of error flags and values. The scoreboard can then detect a lost or swapped error tag as well as bad ordering. A burst that fills the FIFO exactly to 11, 12, 16 and 17 entries tells apart a ready threshold that is off by one, a ready that tracks full instead, and an overflow that either overwrites or fails to latch. Each strobe is repeated with chip-select high and with the select line in the opposite state. This tells correct steering and gating apart from decoding on the strobe alone. Reads are made under both select values, which separates the reply path from the zero path.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              err;
        logic [BYTE_W-1:0] data;
    } fifo_ent_t;

    typedef struct packed {
        logic              cs_n;
        logic              rd_n;
        logic              wr_n;
        logic              cd;
        logic              err;
        logic [BYTE_W-1:0] d;
    } host_smp_t;

    localparam host_smp_t HOST_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                        cd: 1'b0, err: 1'b0, d: '0};

    function automatic logic strobe_done(input logic now_n, input logic prev_n,
                                         input logic prev_cs_n);
        return now_n & ~prev_n & ~prev_cs_n;
    endfunction

endpackage

// File: rtl/hbp_host_sync.sv
module hbp_host_sync
    import hbp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_smp_t raw,
    output host_smp_t held,
    output logic      wr_done,
    output logic      rd_done
);
    host_smp_t stage1;
    host_smp_t stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= HOST_IDLE;
            stage2 <= HOST_IDLE;
        end else begin
            stage1 <= raw;
            stage2 <= stage1;
        end
    end

    assign held    = stage2;
    assign wr_done = strobe_done(stage1.wr_n, stage2.wr_n, stage2.cs_n);
    assign rd_done = strobe_done(stage1.rd_n, stage2.rd_n, stage2.cs_n);

    assert_wr_needs_cs_R9: assert property (@(posedge clk) disable iff (rst)
        wr_done |-> $past(!raw.cs_n, 2));
endmodule

// File: rtl/hbp_fifo.sv
module hbp_fifo
    import hbp_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int READY_FREE = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  fifo_ent_t push_ent,
    input  logic      pop,
    output fifo_ent_t head,
    output logic      not_empty,
    output logic      ready,
    output logic      ovf
);
    localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int READY_LIM = DEPTH - READY_FREE;

    fifo_ent_t            mem [DEPTH];
    logic [PTR_W-1:0]     wptr, rptr;
    logic [CNT_W-1:0]     count;
    logic                 full, do_push, do_pop;

    assign full      = (count == CNT_W'(DEPTH));
    assign not_empty = (count != '0);
    assign do_push   = push & ~full;
    assign do_pop    = pop & not_empty;
    assign head      = mem[rptr];
    assign ready     = (count < CNT_W'(READY_LIM));

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push & full) ovf <= 1'b1;
        end
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)) && ovf);
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (rst)
        (pop && !not_empty && !push) |=> !not_empty);
    assert_not_ready_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
        !ready |-> not_empty);
endmodule

// File: rtl/hbp_regs.sv
module hbp_regs
    import hbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [BYTE_W-1:0] cmd_in,
    input  logic              cmd_take,
    input  logic              reply_load,
    input  logic [BYTE_W-1:0] reply_in,
    input  logic              reply_read,
    output logic [BYTE_W-1:0] cmd_word,
    output logic              cmd_pending,
    output logic [BYTE_W-1:0] reply_word,
    output logic              reply_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_word    <= '0;
            cmd_pending <= 1'b0;
            reply_word  <= '0;
            reply_valid <= 1'b0;
        end else begin
            if (cmd_wr) begin
                cmd_word    <= cmd_in;
                cmd_pending <= 1'b1;
            end else if (cmd_take) begin
                cmd_pending <= 1'b0;
            end
            if (reply_load) begin
                reply_word  <= reply_in;
                reply_valid <= 1'b1;
            end else if (reply_read) begin
                reply_valid <= 1'b0;
            end
        end
    end

    assert_cmd_sets_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> cmd_pending && (cmd_word == $past(cmd_in)));
    assert_take_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_take && !cmd_wr) |=> !cmd_pending && $stable(cmd_word));
    assert_reply_sets_R8: assert property (@(posedge clk) disable iff (rst)
        reply_load |=> reply_valid);
    assert_reply_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (reply_read && !reply_load) |=> !reply_valid);
endmodule

// File: rtl/hbyte_port.sv
module hbyte_port
    import hbp_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int READY_FREE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_cd,
    input  logic              host_err,
    input  logic [BYTE_W-1:0] host_d_in,
    output logic [BYTE_W-1:0] host_d_out,
    output logic              host_d_oe,
    output logic              host_ready,
    input  logic              fifo_pop,
    output logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_err,
    output logic              fifo_valid,
    output logic              fifo_ovf,
    output logic [BYTE_W-1:0] cmd_word,
    output logic              cmd_pending,
    input  logic              cmd_take,
    input  logic              reply_load,
    input  logic [BYTE_W-1:0] reply_in,
    output logic              reply_valid
);
    host_smp_t         raw_smp, held_smp;
    logic              wr_done, rd_done;
    fifo_ent_t         head_ent;
    logic [BYTE_W-1:0] reply_word;

    assign raw_smp = '{cs_n: host_cs_n, rd_n: host_rd_n, wr_n: host_wr_n,
                       cd: host_cd, err: host_err, d: host_d_in};

    hbp_host_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .raw     (raw_smp),
        .held    (held_smp),
        .wr_done (wr_done),
        .rd_done (rd_done)
    );

    hbp_fifo #(.DEPTH(DEPTH), .READY_FREE(READY_FREE)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_done & ~held_smp.cd),
        .push_ent  ('{err: held_smp.err, data: held_smp.d}),
        .pop       (fifo_pop),
        .head      (head_ent),
        .not_empty (fifo_valid),
        .ready     (host_ready),
        .ovf       (fifo_ovf)
    );

    hbp_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (wr_done & held_smp.cd),
        .cmd_in      (held_smp.d),
        .cmd_take    (cmd_take),
        .reply_load  (reply_load),
        .reply_in    (reply_in),
        .reply_read  (rd_done & held_smp.cd),
        .cmd_word    (cmd_word),
        .cmd_pending (cmd_pending),
        .reply_word  (reply_word),
        .reply_valid (reply_valid)
    );

    assign fifo_data  = head_ent.data;
    assign fifo_err   = head_ent.err;
    assign host_d_oe  = ~host_cs_n & ~host_rd_n;
    assign host_d_out = (host_d_oe && host_cd) ? reply_word : '0;

    assert_drive_gated_R7: assert property (@(posedge clk) disable iff (rst)
        (host_d_out != '0) |-> (host_d_oe && host_cd));
endmodule

// File: tb/hbyte_port_tb_top.sv
module hbyte_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0, err = 1'b0;
    logic [7:0] d_in = '0;
    logic [7:0] d_out;
    logic       d_oe, ready, pop = 1'b0, f_err, f_valid, f_ovf;
    logic [7:0] f_data, cmd_w, rep_in = '0;
    logic       cmd_pend, take = 1'b0, rep_load = 1'b0, rep_valid;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    logic [8:0] expq [$];

    always #10 clk = ~clk;

    hbyte_port dut_i (
        .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .host_cd(cd), .host_err(err), .host_d_in(d_in), .host_d_out(d_out),
        .host_d_oe(d_oe), .host_ready(ready), .fifo_pop(pop), .fifo_data(f_data),
        .fifo_err(f_err), .fifo_valid(f_valid), .fifo_ovf(f_ovf), .cmd_word(cmd_w),
        .cmd_pending(cmd_pend), .cmd_take(take), .reply_load(rep_load),
        .reply_in(rep_in), .reply_valid(rep_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FIFO-port FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: host write; a data write is queued as expected when the model has room
    task automatic host_write(input logic sel, input logic e, input logic [7:0] v,
                              input logic with_cs);
        @(negedge clk);
        cs_n = ~with_cs; cd = sel; err = e; d_in = v; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        if (with_cs && !sel && expq.size() < 16) expq.push_back({e, v});
    endtask

    task automatic host_read(input logic sel, input logic with_cs, output logic oe,
                             output logic [7:0] v);
        @(negedge clk);
        cs_n = ~with_cs; cd = sel; rd_n = 1'b0;
        @(negedge clk);
        oe = d_oe; v = d_out;
        rd_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
    endtask

    // monitor: pops the FIFO and compares against the scoreboard queue (R4)
    task automatic drain();
        while (f_valid) begin
            logic [8:0] e;
            e = (expq.size() > 0) ? expq.pop_front() : 9'h1ff;
            chk("R4 head entry", {f_err, f_data}, e);
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
        end
        chk("R4 queue drained", expq.size(), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic       oe;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", ready, 1); chk("R1 fifo_valid", f_valid, 0);
        chk("R1 ovf", f_ovf, 0); chk("R1 cmd_pending", cmd_pend, 0);
        chk("R1 reply_valid", rep_valid, 0); chk("R1 oe", d_oe, 0);
        chk("R1 cmd_word", cmd_w, 0);

        // R8 reply load then host read
        rep_in = 8'hA5; rep_load = 1'b1; @(negedge clk); rep_load = 1'b0;
        chk("R8 reply_valid set", rep_valid, 1);
        // R9 read with chip-select high
        host_read(1'b1, 1'b0, oe, v);
        chk("R7 no drive without cs", oe, 0);
        chk("R9 reply_valid kept", rep_valid, 1);
        host_read(1'b1, 1'b1, oe, v);
        chk("R7 oe on read", oe, 1); chk("R7 reply on bus", v, 8'hA5);
        chk("R8 reply_valid cleared", rep_valid, 0);
        // R7 read with cd=0 returns zero; R8 does not clear reply
        rep_in = 8'h5A; rep_load = 1'b1; @(negedge clk); rep_load = 1'b0;
        host_read(1'b0, 1'b1, oe, v);
        chk("R7 oe cd0", oe, 1); chk("R7 zero on cd0", v, 8'h00);
        chk("R8 cd0 read keeps valid", rep_valid, 1);

        // R2 command write
        host_write(1'b1, 1'b0, 8'h3C, 1'b1);
        chk("R2 cmd_word", cmd_w, 8'h3C); chk("R2 cmd_pending", cmd_pend, 1);
        chk("R2 fifo untouched", f_valid, 0);
        // R3 take
        take = 1'b1; @(negedge clk); take = 1'b0;
        chk("R3 pending cleared", cmd_pend, 0); chk("R3 cmd_word kept", cmd_w, 8'h3C);
        // R9 write with chip-select high
        host_write(1'b1, 1'b0, 8'h77, 1'b0);
        chk("R9 cmd_word kept", cmd_w, 8'h3C); chk("R9 pending kept", cmd_pend, 0);
        host_write(1'b0, 1'b0, 8'h11, 1'b0);
        chk("R9 fifo untouched", f_valid, 0);

        // R4 data writes with mixed error tags
        host_write(1'b0, 1'b0, 8'h01, 1'b1);
        host_write(1'b0, 1'b1, 8'hFE, 1'b1);
        host_write(1'b0, 1'b0, 8'h80, 1'b1);
        host_write(1'b0, 1'b1, 8'h00, 1'b1);
        host_write(1'b0, 1'b0, 8'h5D, 1'b1);
        chk("R2 pending not set by data", cmd_pend, 0);
        drain();

        // R10 pop on empty
        pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
        chk("R10 still empty", f_valid, 0);

        // R5/R6 fill
        for (int i = 0; i < 11; i++) host_write(1'b0, i[0], 8'(8'h20 + i), 1'b1);
        chk("R5 ready at 11", ready, 1);
        host_write(1'b0, 1'b1, 8'h2B, 1'b1);
        chk("R5 not ready at 12", ready, 0);
        for (int i = 0; i < 4; i++) host_write(1'b0, 1'b0, 8'(8'h40 + i), 1'b1);
        chk("R6 no ovf at 16", f_ovf, 0);
        host_write(1'b0, 1'b1, 8'hEE, 1'b1);
        chk("R6 ovf set", f_ovf, 1);
        drain();
        chk("R6 ovf sticky", f_ovf, 1);
        chk("R5 ready after drain", ready, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule